// File: doc/BRIEF.md
# Self-Timed Program Cycle Controller

This block sits behind the serial front end of a small nonvolatile word memory. It receives fully decoded commands and sequences the self-timed program operations on the storage: erasing one word, writing one word, erasing the whole array, and writing one value to the whole array. It also keeps a write-enable latch that software must set before any erase or write takes effect. The storage is modelled as a synchronous word array inside the block. It has one write port, driven only by the sequencer, and a combinational read port that the front end uses for reads.

Each program operation holds the block busy for a fixed number of clock cycles. Each count is a parameter. The single-word and erase-all counts stand for the nominal 6 ms. The write-all count stands for the nominal 15 ms. The ready flag is the value the front end drives onto its status line. Once a program cycle starts, it runs to its end whatever chip select does. A supply-low input stands in for the analog supply monitor and blocks all programming.

Top module: `prog_cycle_ctrl`

## Requirements
- R1: After reset the write-enable latch is clear. Every erase or write command is then ignored: no busy period starts and the array is left unchanged, until an enable command is accepted.
- R2: cmd_op codes are 0 no operation, 1 erase word, 2 write word, 3 erase all, 4 write all, 5 enable, 6 disable. Enable (5) sets the latch and disable (6) clears it. Neither one starts a busy period.
- R3: An accepted erase-word command sets the addressed word to all ones. It keeps ready_o low for exactly T_WORD cycles, starting in the cycle after the accepting clock edge.
- R4: An accepted write-word command stores cmd_data at cmd_addr. It keeps ready_o low for exactly T_WORD cycles.
- R5: An accepted erase-all command sets every word to all ones. It keeps ready_o low for exactly T_ERAL cycles.
- R6: An accepted write-all command first sets every word to all ones and then writes cmd_data to every word. It keeps ready_o low for exactly T_WRAL cycles.
- R7: Any command presented while ready_o is low is ignored, including enable and disable. The latch keeps its value.
- R8: A command is only accepted while cs_i is high. A program cycle that has started completes even if cs_i goes low during it.
- R9: While supply_low is high, no erase or write command starts and the array is not written.
- R10: ready_o is 1 when the block is ready and 0 when it is busy. It is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_i | input | 1 | Chip select; commands are accepted only while it is high |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | AW | Word address for single-word commands |
| cmd_data | input | DW | Data word for write commands |
| supply_low | input | 1 | Supply below the programming threshold |
| rd_addr | input | AW | Read address |
| ready_o | output | 1 | 1 = ready, 0 = program cycle in progress |
| rd_data | output | DW | Word stored at rd_addr |

## Verification
The assertions assume that reset is held for at least one clock edge before the first command. They also assume that the three cycle counts cover the address sweeps: T_ERAL must be at least the depth and T_WRAL at least twice the depth, so each sweep ends before busy drops. The bench keeps the default counts, which meet these limits. It changes cs_i, cmd_valid and supply_low only at the falling clock edge. Those changes include commands issued during busy periods and chip select dropped in the middle of a cycle.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_ERASE     = 3'd1,
        OP_WRITE     = 3'd2,
        OP_ERASE_ALL = 3'd3,
        OP_WRITE_ALL = 3'd4,
        OP_UNLOCK    = 3'd5,
        OP_LOCK      = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ONE,
        PH_CLEAR,
        PH_FILL
    } phase_e;

    function automatic logic is_program(op_e op);
        return (op == OP_ERASE) || (op == OP_WRITE) ||
               (op == OP_ERASE_ALL) || (op == OP_WRITE_ALL);
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/pcc_array.sv
module pcc_array #(
    parameter int DW    = 16,
    parameter int DEPTH = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/pcc_timer.sv
module pcc_timer #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          idle
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= len;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign idle = (cnt == '0);

    // R3: a running cycle counts down by one per clock
    p_countdown_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
    import pcc_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_i,
    input  logic          cmd_valid,
    input  op_e           op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          supply_low,
    input  logic          idle,
    output logic          start,
    output logic          wel,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [DW-1:0] BLANK = '1;

    phase_e        phase;
    logic [AW-1:0] ptr;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          fill_after;
    logic          accept;

    assign accept = cmd_valid && cs_i && idle;
    assign start  = accept && is_program(op) && wel && !supply_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel        <= 1'b0;
            phase      <= PH_IDLE;
            ptr        <= '0;
            addr_q     <= '0;
            data_q     <= '0;
            fill_after <= 1'b0;
        end else begin
            if (accept && op == OP_UNLOCK) wel <= 1'b1;
            if (accept && op == OP_LOCK)   wel <= 1'b0;
            if (start) begin
                ptr        <= '0;
                addr_q     <= cmd_addr;
                data_q     <= (op == OP_ERASE) ? BLANK : cmd_data;
                fill_after <= (op == OP_WRITE_ALL);
                phase      <= (op == OP_ERASE || op == OP_WRITE) ? PH_ONE : PH_CLEAR;
            end else begin
                unique case (phase)
                    PH_ONE: phase <= PH_IDLE;
                    PH_CLEAR: begin
                        ptr <= ptr + 1'b1;
                        if (ptr == LAST) begin
                            ptr   <= '0;
                            phase <= fill_after ? PH_FILL : PH_IDLE;
                        end
                    end
                    PH_FILL: begin
                        ptr <= ptr + 1'b1;
                        if (ptr == LAST) begin
                            ptr   <= '0;
                            phase <= PH_IDLE;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    assign wr_en   = (phase != PH_IDLE) && !supply_low;
    assign wr_addr = (phase == PH_ONE) ? addr_q : ptr;
    assign wr_data = (phase == PH_CLEAR) ? BLANK : data_q;

    // R7: the latch cannot move while a program cycle runs
    p_latch_frozen_busy_r7: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(wel));

    // R6: the fill sweep is entered only from the clear sweep
    p_fill_after_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FILL) |-> ($past(phase) == PH_FILL || $past(phase) == PH_CLEAR));

endmodule

// File: rtl/prog_cycle_ctrl.sv
module prog_cycle_ctrl
    import pcc_pkg::*;
#(
    parameter bit WIDE_ORG = 1'b1,
    parameter int T_WORD   = 600,
    parameter int T_ERAL   = 600,
    parameter int T_WRAL   = 1500,
    localparam int DW      = WIDE_ORG ? 16 : 8,
    localparam int DEPTH   = WIDE_ORG ? 128 : 256,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_i,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          supply_low,
    input  logic [AW-1:0] rd_addr,
    output logic          ready_o,
    output logic [DW-1:0] rd_data
);

    localparam int TMAX = max3(T_WORD, T_ERAL, T_WRAL);
    localparam int CW   = $clog2(TMAX + 1);

    op_e           op;
    logic          start;
    logic          wel;
    logic          idle;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [CW-1:0] len;

    assign op = op_e'(cmd_op);

    always_comb begin
        unique case (op)
            OP_ERASE_ALL: len = CW'(T_ERAL);
            OP_WRITE_ALL: len = CW'(T_WRAL);
            default:      len = CW'(T_WORD);
        endcase
    end

    pcc_seq #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .cs_i       (cs_i),
        .cmd_valid  (cmd_valid),
        .op         (op),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .supply_low (supply_low),
        .idle       (idle),
        .start      (start),
        .wel        (wel),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    pcc_timer #(.CW(CW)) i_timer (
        .clk  (clk),
        .rst  (rst),
        .load (start),
        .len  (len),
        .idle (idle)
    );

    pcc_array #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) i_array (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign ready_o = idle;

    // R1: a busy period only begins when the latch was set
    p_start_needs_latch_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_o) |-> $past(wel));

    // R9: a busy period never begins under a low supply
    p_start_needs_supply_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_o) |-> $past(!supply_low));

    // R10: the array is written only while busy is reported
    p_write_inside_busy_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !ready_o);

endmodule

// File: tb/test_prog_cycle_ctrl.sv
module test_prog_cycle_ctrl;

    localparam int DW = 16;
    localparam int DEPTH = 128;
    localparam int AW = 7;
    localparam int TW = 600;
    localparam int TE = 600;
    localparam int TA = 1500;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_i = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          supply_low = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          ready_o;
    logic [DW-1:0] rd_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [DW-1:0] m_mem [DEPTH];
    bit m_wel = 1'b0;
    int m_cnt = 0;

    prog_cycle_ctrl #(.T_WORD(TW), .T_ERAL(TE), .T_WRAL(TA)) i_prog_cycle_ctrl (
        .clk(clk), .rst(rst), .cs_i(cs_i), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .supply_low(supply_low),
        .rd_addr(rd_addr), .ready_o(ready_o), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    initial begin
        while (cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        total++;
        bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one clock: reference model at the edge, compare ready at the falling edge
    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_wel = 1'b0;
            m_cnt = 0;
        end else if (m_cnt > 0) begin
            m_cnt--;
        end else if (cmd_valid && cs_i) begin
            case (cmd_op)
                3'd5: m_wel = 1'b1;
                3'd6: m_wel = 1'b0;
                3'd1, 3'd2, 3'd3, 3'd4: if (m_wel && !supply_low) begin
                    if (cmd_op == 3'd1) begin m_mem[cmd_addr] = '1; m_cnt = TW; end
                    if (cmd_op == 3'd2) begin m_mem[cmd_addr] = cmd_data; m_cnt = TW; end
                    if (cmd_op == 3'd3) begin
                        for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
                        m_cnt = TE;
                    end
                    if (cmd_op == 3'd4) begin
                        for (int i = 0; i < DEPTH; i++) m_mem[i] = cmd_data;
                        m_cnt = TA;
                    end
                end
                default: ;
            endcase
        end
        @(negedge clk);
        check("R10 ready", int'(ready_o), (m_cnt == 0) ? 1 : 0);
    endtask

    task automatic issue(input int op, input int addr, input int data);
        cmd_valid = 1'b1;
        cmd_op = 3'(op);
        cmd_addr = AW'(addr);
        cmd_data = DW'(data);
        step();
        cmd_valid = 1'b0;
    endtask

    // issue a program command and measure the busy window
    task automatic prog(input string tag, input int op, input int addr, input int data, input int exp_len);
        int n;
        issue(op, addr, data);
        n = 0;
        while (!ready_o && n < 5000) begin
            n++;
            step();
        end
        check(tag, n, exp_len);
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic check_mem(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            #0.1;
            check(tag, int'(rd_data), int'(m_mem[a]));
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '1;
        @(negedge clk);
        settle(4);
        rst = 1'b0;
        check("R10 ready after reset", int'(ready_o), 1);
        // R1: write with the latch clear after reset does nothing
        prog("R1 busy without enable", 2, 5, 16'h1234, 0);
        // R2 enable, R5 erase all
        issue(5, 0, 0);
        check("R2 enable starts no busy", int'(ready_o), 1);
        prog("R5 erase-all length", 3, 0, 0, TE);
        check_mem("R5 array blank");
        // R1 again: reset clears the latch
        rst = 1'b1; settle(2); rst = 1'b0;
        prog("R1 write ignored after reset", 2, 5, 16'h1234, 0);
        check_mem("R1 array unchanged");
        issue(5, 0, 0);
        prog("R4 write length", 2, 5, 16'h1234, TW);
        prog("R4 write length", 2, 127, 16'hBEEF, TW);
        prog("R4 write length", 2, 0, 16'h0001, TW);
        check_mem("R4 words stored");
        prog("R3 erase length", 1, 5, 16'h0000, TW);
        check_mem("R3 word blank");
        // R7: commands during busy are ignored, latch kept
        issue(2, 9, 16'h5555);
        settle(3);
        issue(6, 0, 0);
        settle(3);
        issue(2, 10, 16'h6666);
        settle(TW);
        check_mem("R7 busy commands ignored");
        prog("R7 latch still set", 2, 11, 16'h7777, TW);
        check_mem("R7 write after busy");
        // R8: cs low during the cycle, and cs low while idle
        issue(2, 20, 16'h2020);
        cs_i = 1'b0;
        settle(TW + 2);
        check_mem("R8 cycle completes with cs low");
        prog("R8 cs low command ignored", 2, 21, 16'h2121, 0);
        check_mem("R8 array unchanged");
        cs_i = 1'b1;
        // R9: supply low blocks programming
        supply_low = 1'b1;
        prog("R9 blocked busy", 2, 30, 16'h3030, 0);
        prog("R9 blocked erase-all", 3, 0, 0, 0);
        supply_low = 1'b0;
        check_mem("R9 array unchanged");
        // R6: write all
        prog("R6 write-all length", 4, 0, 16'hA5C3, TA);
        check_mem("R6 all words filled");
        prog("R5 erase-all length", 3, 0, 0, TE);
        check_mem("R5 array blank again");
        // R2: disable blocks later writes
        issue(6, 0, 0);
        check("R2 disable starts no busy", int'(ready_o), 1);
        prog("R2 write after disable", 2, 3, 16'h0303, 0);
        check_mem("R2 array unchanged");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule